// File: doc/BRIEF.md
# Write-Masked PHY Configuration Register Bank

This block holds the static configuration of a storage-card PHY in seven 32-bit control registers and exposes one read-only status register, all reached over a plain single-cycle bus with address, write data, write strobe, read strobe and read data. Each write carries its own bit mask: the upper half of the write data says which bits of the lower half are to be changed. Software can therefore flip one field, such as the DLL enable, without first reading the register back.

The lower halves of all control registers leave the block on a flat bus. The fields the PHY needs directly also come out on their own ports: power-up, DLL enable, drive-strength code, DLL frequency band, output tap-delay enable and tap-delay select. A 16-bit status word from the PHY is sampled into a flop every cycle, and software reads it at the status offset.

Top module: `phycfg_regbank`

## Requirements
- R1: While reset is asserted, and once it is released, every control register, every field port and `bus_rdata` are zero. This leaves the PHY powered down with the DLL off.
- R2: A write to a control register changes lower bit x only when `bus_wdata[x+16]` is 1. Every other lower bit keeps its value.
- R3: Bits 31:16 of every control register always read as zero, whatever was written to them.
- R4: Control register k sits at byte offset 4*k, for k = 0 to 6. A write reaches only the register it addresses.
- R5: A read of byte offset 0x20 returns `{16'h0, s}`, where s is `stat_in` as it stood at the clock edge before the read strobe is sampled. Bit 6 of s is calibration done and bit 5 is DLL ready.
- R6: A write to offset 0x20 has no effect on any register.
- R7: A read of any other offset returns zero, and a write to it changes nothing. This covers 0x1C, 0x24 to 0x3F and every offset whose two low bits are not zero.
- R8: The field ports follow the register contents. `phy_pwr_up` is bit 0 of register 6 and `dll_en` is bit 1. `drv_code` is bits 6:4 of register 6 (0=50, 1=33, 2=66, 3=100, 4=40 ohm). `dll_freq` is bits 13:12 of register 0 (0=200, 1=50, 2=100, 3=150 MHz). `otap_en` is bit 11 of register 0 and `otap_sel` is bits 10:7. Register k's lower half is `ctrl_flat[16k+15:16k]`. Every field port shows a write from the clock edge that performs it.
- R9: Read data appears in the cycle after the edge that samples `bus_rd`, and is zero when `bus_rd` was low. A read issued in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data: mask in 31:16, value in 15:0 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| stat_in | input | 16 | Status word from the PHY |
| ctrl_flat | output | 112 | Lower halves of the seven control registers |
| phy_pwr_up | output | 1 | PHY power-up (power-down released) |
| dll_en | output | 1 | DLL enable |
| drv_code | output | 3 | Drive-strength code |
| dll_freq | output | 2 | DLL frequency band |
| otap_en | output | 1 | Output tap-delay enable |
| otap_sel | output | 4 | Output tap-delay select |

## Verification
A write becomes visible on the field ports and on `ctrl_flat` one edge after the strobe. A read result arrives on `bus_rdata` one edge after its strobe. A change on `stat_in` needs two edges before a read can return it: one edge to sample it and one to return it. The bench drives every operation at a falling edge and compares at the next falling edge, so each result is taken half a cycle after the edge that produces it. The status test deliberately reads in the same cycle that `stat_in` changes and expects the old value, then waits one cycle and expects the new value.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

   // Field placement, fixed because the PHY decodes these bit positions
   localparam int unsigned TIMING_REG = 0;
   localparam int unsigned MISC_REG   = 6;

   localparam int unsigned PWR_BIT    = 0;
   localparam int unsigned DLLEN_BIT  = 1;
   localparam int unsigned DRV_LSB    = 4;
   localparam int unsigned DRV_W      = 3;
   localparam int unsigned OTSEL_LSB  = 7;
   localparam int unsigned OTSEL_W    = 4;
   localparam int unsigned OTEN_BIT   = 11;
   localparam int unsigned FREQ_LSB   = 12;
   localparam int unsigned FREQ_W     = 2;

   typedef enum logic [FREQ_W-1:0] {
      BAND_200M = 2'd0,
      BAND_50M  = 2'd1,
      BAND_100M = 2'd2,
      BAND_150M = 2'd3
   } dll_band_e;

   typedef enum logic [DRV_W-1:0] {
      DRV_OHM50  = 3'd0,
      DRV_OHM33  = 3'd1,
      DRV_OHM66  = 3'd2,
      DRV_OHM100 = 3'd3,
      DRV_OHM40  = 3'd4
   } drv_ohm_e;

endpackage

// File: rtl/phycfg_mask_reg.sv
module phycfg_mask_reg #(
   parameter int unsigned HALF_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [2*HALF_W-1:0]   wdata,
   output logic [HALF_W-1:0]     q
);

   logic [HALF_W-1:0] msk;
   logic [HALF_W-1:0] val;

   assign msk = wdata[2*HALF_W-1:HALF_W];
   assign val = wdata[HALF_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= (q & ~msk) | (val & msk);
      end
   end

endmodule

// File: rtl/phycfg_addr_dec.sv
module phycfg_addr_dec #(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned N_CTRL   = 7,
   parameter int unsigned LSB      = 2,
   parameter int unsigned STAT_OFS = 32
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [N_CTRL-1:0]  ctrl_sel,
   output logic               stat_sel
);

   localparam int unsigned WORD_W = ADDR_W - LSB;

   logic              aligned;
   logic [WORD_W-1:0] word;

   assign aligned  = (addr[LSB-1:0] == '0);
   assign word     = addr[ADDR_W-1:LSB];
   assign stat_sel = (addr == ADDR_W'(STAT_OFS));

   for (genvar i = 0; i < N_CTRL; i++) begin : g_sel
      assign ctrl_sel[i] = aligned && (word == WORD_W'(i));
   end

endmodule

// File: rtl/phycfg_rd_mux.sv
module phycfg_rd_mux #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned N_CTRL   = 7,
   parameter bit          READ_REG = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd,
   input  logic [N_CTRL-1:0]            ctrl_sel,
   input  logic                         stat_sel,
   input  logic [N_CTRL*DATA_W/2-1:0]   ctrl_flat,
   input  logic [DATA_W/2-1:0]          stat_q,
   output logic [DATA_W-1:0]            rdata
);

   localparam int unsigned HALF_W = DATA_W / 2;

   logic [HALF_W-1:0] low_word;
   logic [DATA_W-1:0] rd_word;

   always_comb begin
      low_word = stat_sel ? stat_q : '0;
      for (int i = 0; i < N_CTRL; i++) begin
         if (ctrl_sel[i]) begin
            low_word = low_word | ctrl_flat[i*HALF_W +: HALF_W];
         end
      end
   end

   assign rd_word = rd ? {{HALF_W{1'b0}}, low_word} : '0;

   if (READ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata <= '0;
         end else begin
            rdata <= rd_word;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rdata = rd_word;
   end

endmodule

// File: rtl/phycfg_regbank.sv
module phycfg_regbank
   import phycfg_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned N_CTRL   = 7,
   parameter int unsigned STAT_OFS = 32,
   parameter bit          READ_REG = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   input  logic                         bus_wr,
   input  logic                         bus_rd,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic [DATA_W/2-1:0]          stat_in,
   output logic [N_CTRL*DATA_W/2-1:0]   ctrl_flat,
   output logic                         phy_pwr_up,
   output logic                         dll_en,
   output logic [DRV_W-1:0]             drv_code,
   output logic [FREQ_W-1:0]            dll_freq,
   output logic                         otap_en,
   output logic [OTSEL_W-1:0]           otap_sel
);

   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned BYTES  = DATA_W / 8;
   localparam int unsigned LSB    = $clog2(BYTES);

   // Elaboration-time parameter checks
   if (DATA_W % 16 != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 16");
   end
   if (N_CTRL * BYTES > STAT_OFS) begin : g_bad_map
      $error("control registers overlap the status offset");
   end
   if (STAT_OFS >= (1 << ADDR_W)) begin : g_bad_addr
      $error("status offset does not fit the address width");
   end
   if (N_CTRL <= MISC_REG || HALF_W <= FREQ_LSB + FREQ_W - 1) begin : g_bad_fields
      $error("register bank too small for the PHY field map");
   end

   logic [N_CTRL-1:0]  ctrl_sel;
   logic               stat_sel;
   logic [HALF_W-1:0]  stat_q;

   phycfg_addr_dec #(
      .ADDR_W   (ADDR_W),
      .N_CTRL   (N_CTRL),
      .LSB      (LSB),
      .STAT_OFS (STAT_OFS)
   ) u_dec (
      .addr     (bus_addr),
      .ctrl_sel (ctrl_sel),
      .stat_sel (stat_sel)
   );

   for (genvar k = 0; k < N_CTRL; k++) begin : g_ctrl
      phycfg_mask_reg #(
         .HALF_W (HALF_W)
      ) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (bus_wr & ctrl_sel[k]),
         .wdata (bus_wdata),
         .q     (ctrl_flat[k*HALF_W +: HALF_W])
      );
   end

   // Status word sampled every cycle; writes never reach it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         stat_q <= stat_in;
      end
   end

   phycfg_rd_mux #(
      .DATA_W   (DATA_W),
      .N_CTRL   (N_CTRL),
      .READ_REG (READ_REG)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd        (bus_rd),
      .ctrl_sel  (ctrl_sel),
      .stat_sel  (stat_sel),
      .ctrl_flat (ctrl_flat),
      .stat_q    (stat_q),
      .rdata     (bus_rdata)
   );

   // Field extraction for the PHY
   logic [HALF_W-1:0] misc_w;
   logic [HALF_W-1:0] timing_w;

   assign misc_w   = ctrl_flat[MISC_REG*HALF_W +: HALF_W];
   assign timing_w = ctrl_flat[TIMING_REG*HALF_W +: HALF_W];

   assign phy_pwr_up = misc_w[PWR_BIT];
   assign dll_en     = misc_w[DLLEN_BIT];
   assign drv_code   = misc_w[DRV_LSB +: DRV_W];
   assign dll_freq   = timing_w[FREQ_LSB +: FREQ_W];
   assign otap_en    = timing_w[OTEN_BIT];
   assign otap_sel   = timing_w[OTSEL_LSB +: OTSEL_W];

endmodule

// File: rtl/phycfg_regbank_chk.sv
module phycfg_regbank_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned N_CTRL   = 7,
   parameter int unsigned STAT_OFS = 32,
   parameter bit          READ_REG = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic                phy_pwr_up,
   input logic [1:0]          dll_freq
);

   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned LSB    = $clog2(DATA_W / 8);
   localparam logic [ADDR_W-1:0] MISC_OFS   = ADDR_W'(6 << LSB);
   localparam logic [ADDR_W-1:0] TIMING_OFS = '0;

   logic ctrl_hit;
   logic unmapped;

   assign ctrl_hit = (bus_addr[LSB-1:0] == '0) && ((bus_addr >> LSB) < N_CTRL);
   assign unmapped = !ctrl_hit && (bus_addr != ADDR_W'(STAT_OFS));

   if (READ_REG) begin : g_rd_idle
      AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_rd |=> (bus_rdata == '0)); // R9
   end

   AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && unmapped) |=> (bus_rdata == '0)); // R7

   AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ctrl_hit) |=> (bus_rdata[DATA_W-1:HALF_W] == '0)); // R3

   AST_PWR_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == MISC_OFS && !bus_wdata[HALF_W]) |=> $stable(phy_pwr_up)); // R2

   AST_PWR_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == MISC_OFS && bus_wdata[HALF_W]) |=> (phy_pwr_up == $past(bus_wdata[0]))); // R8

   AST_FREQ_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == TIMING_OFS) |=> $stable(dll_freq)); // R4

endmodule

bind phycfg_regbank phycfg_regbank_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .N_CTRL   (N_CTRL),
   .STAT_OFS (STAT_OFS),
   .READ_REG (READ_REG)
) u_chk (.*);

// File: tb/phycfg_regbank_bench.sv
module phycfg_regbank_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [5:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [31:0]  bus_rdata;
   logic [15:0]  stat_in = '0;
   logic [111:0] ctrl_flat;
   logic         phy_pwr_up;
   logic         dll_en;
   logic [2:0]   drv_code;
   logic [1:0]   dll_freq;
   logic         otap_en;
   logic [3:0]   otap_sel;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   phycfg_regbank u_phycfg_regbank (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_rdata  (bus_rdata),
      .stat_in    (stat_in),
      .ctrl_flat  (ctrl_flat),
      .phy_pwr_up (phy_pwr_up),
      .dll_en     (dll_en),
      .drv_code   (drv_code),
      .dll_freq   (dll_freq),
      .otap_en    (otap_en),
      .otap_sel   (otap_sel)
   );

   // {wr, rd, addr[5:0], wdata[31:0], expected rdata[31:0]}
   localparam int NV = 22;
   localparam logic [71:0] VEC [NV] = '{
      {1'b1, 1'b0, 6'h18, 32'h00FF_0043, 32'h0},         // R2 R4: reg6 <= 0x43
      {1'b0, 1'b1, 6'h18, 32'h0,         32'h0000_0043}, // R4
      {1'b1, 1'b0, 6'h18, 32'h0002_0000, 32'h0},         // R2: clear bit1 only
      {1'b0, 1'b1, 6'h18, 32'h0,         32'h0000_0041}, // R2
      {1'b1, 1'b0, 6'h00, 32'h3F80_2A00, 32'h0},         // R2: bits 13:7 masked
      {1'b0, 1'b1, 6'h00, 32'h0,         32'h0000_2A00}, // R4
      {1'b1, 1'b0, 6'h00, 32'h0000_FFFF, 32'h0},         // R2: empty mask
      {1'b0, 1'b1, 6'h00, 32'h0,         32'h0000_2A00}, // R2
      {1'b1, 1'b0, 6'h0C, 32'hFFFF_1234, 32'h0},         // R4
      {1'b0, 1'b1, 6'h0C, 32'h0,         32'h0000_1234}, // R4
      {1'b0, 1'b1, 6'h08, 32'h0,         32'h0},         // R4: untouched neighbour
      {1'b1, 1'b0, 6'h1C, 32'hFFFF_FFFF, 32'h0},         // R7: unmapped write
      {1'b0, 1'b1, 6'h1C, 32'h0,         32'h0},         // R7
      {1'b1, 1'b0, 6'h20, 32'hFFFF_FFFF, 32'h0},         // R6: status write
      {1'b0, 1'b1, 6'h14, 32'h0,         32'h0},         // R6 R7
      {1'b0, 1'b1, 6'h04, 32'h0,         32'h0},         // R6 R7
      {1'b0, 1'b1, 6'h10, 32'h0,         32'h0},         // R6 R7
      {1'b1, 1'b0, 6'h0D, 32'hFFFF_0000, 32'h0},         // R7: misaligned write
      {1'b0, 1'b1, 6'h0C, 32'h0,         32'h0000_1234}, // R7
      {1'b0, 1'b1, 6'h3C, 32'h0,         32'h0},         // R7
      {1'b1, 1'b0, 6'h14, 32'hFFFF_FFFF, 32'h0},         // R3
      {1'b0, 1'b1, 6'h14, 32'h0,         32'h0000_FFFF}  // R3: upper reads zero
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge with inputs idle
   task automatic op(input logic wr, input logic rd, input logic [5:0] a, input logic [31:0] d);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic chk_fields_zero(input string tag);
      chk({tag, " ctrl_flat low"}, ctrl_flat[31:0], 32'h0);
      chk({tag, " ctrl_flat mid"}, ctrl_flat[95:32] == 64'h0 ? 32'h0 : 32'h1, 32'h0);
      chk({tag, " ctrl_flat reg6"}, {16'h0, ctrl_flat[111:96]}, 32'h0);
      chk({tag, " fields"}, {21'h0, phy_pwr_up, dll_en, drv_code, dll_freq, otap_en, otap_sel}, 32'h0);
      chk({tag, " rdata"}, bus_rdata, 32'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk_fields_zero("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_fields_zero("R1 after release");

      for (int i = 0; i < NV; i++) begin
         op(VEC[i][71], VEC[i][70], VEC[i][69:64], VEC[i][63:32]);
         if (VEC[i][70]) begin
            chk($sformatf("R2/R3/R4/R6/R7 vector %0d", i), bus_rdata, VEC[i][31:0]);
         end
      end

      // R8: decoded fields from reg6 = 0x0041, reg0 = 0x2A00
      chk("R8 pwr_up", {31'h0, phy_pwr_up}, 32'h1);
      chk("R8 dll_en", {31'h0, dll_en}, 32'h0);
      chk("R8 drv_code 40 ohm", {29'h0, drv_code}, 32'h4);
      chk("R8 dll_freq 100 MHz", {30'h0, dll_freq}, 32'h2);
      chk("R8 otap_en", {31'h0, otap_en}, 32'h1);
      chk("R8 otap_sel", {28'h0, otap_sel}, 32'h4);
      chk("R8 ctrl_flat reg3", {16'h0, ctrl_flat[63:48]}, 32'h0000_1234);
      chk("R8 ctrl_flat reg5", {16'h0, ctrl_flat[95:80]}, 32'h0000_FFFF);

      // R8: field visible right after the write edge
      op(1'b1, 1'b0, 6'h18, 32'h0002_0002);
      chk("R8 dll_en after write", {31'h0, dll_en}, 32'h1);

      // R5: status sampling latency
      stat_in = 16'h0060;
      @(negedge clk);
      op(1'b0, 1'b1, 6'h20, 32'h0);
      chk("R5 status cal+dll ready", bus_rdata, 32'h0000_0060);
      stat_in = 16'h0040;
      op(1'b0, 1'b1, 6'h20, 32'h0);
      chk("R5 status same-cycle old value", bus_rdata, 32'h0000_0060);
      op(1'b0, 1'b1, 6'h20, 32'h0);
      chk("R5 status cal done only", bus_rdata, 32'h0000_0040);

      // R9: read during write returns old value, then new
      op(1'b1, 1'b1, 6'h08, 32'hFFFF_ABCD);
      chk("R9 read-during-write old", bus_rdata, 32'h0);
      op(1'b0, 1'b1, 6'h08, 32'h0);
      chk("R9 read after write", bus_rdata, 32'h0000_ABCD);
      @(negedge clk);
      chk("R9 idle rdata zero", bus_rdata, 32'h0);

      // R1: reset in mid-run clears everything
      rst_n = 1'b0;
      @(negedge clk);
      chk_fields_zero("R1 mid-run reset");
      rst_n = 1'b1;
      @(negedge clk);
      op(1'b0, 1'b1, 6'h08, 32'h0);
      chk("R1 reg2 cleared", bus_rdata, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule